// File: doc/BRIEF.md
# Stepped Frequency Sweep Sequencer

This block generates a linear frequency sweep as a 24-bit tuning word and feeds that word into its own phase accumulator. A one-cycle start pulse samples the sweep settings. The block then outputs the start word, holds it for one dwell, and moves the word by a signed step after each dwell. It stops once the programmed number of steps has been taken. No end frequency is stored anywhere. The final word follows from the start word, the step and the step count.

The dwell can be counted in one of two units. The first is master clock periods. The second is complete periods of the waveform being generated, which are detected as carries out of the phase accumulator. A busy flag covers the whole sweep. A one-cycle done pulse marks its end, and the last word stays on the output until the next start. The phase value is exposed so that a waveform lookup can follow.

Top module: `sweep_seq`

## Requirements
- R1: In the cycle after a start pulse is sampled, `tuning_word` equals `start_word` and `busy` is 1.
- R2: At the end of each dwell that is not the last, the tuning word changes by the step, modulo 2^24. The step is the 23-bit `step_mag`, added when `step_neg`=0 and subtracted when `step_neg`=1.
- R3: A sweep with step count N outputs N+1 frequencies. The final word equals start + N × signed step, modulo 2^24.
- R4: With `dwell_by_cycles`=0, each frequency is held for exactly D clock cycles, so a whole sweep is busy for (N+1)×D cycles.
- R5: `phase` adds the tuning word on every clock, modulo 2^24. With `dwell_by_cycles`=1, the dwell count drops once for each carry out of that addition, in the cycle after the carry.
- R6: A dwell count below 2 is treated as 2. A step count below 2 is treated as 2. The fields are 11 bits and 12 bits wide, so the largest values are 2047 and 4095.
- R7: `done` is high for exactly one cycle, at the same edge where `busy` falls. The final word is then held until the next start.
- R8: A start pulse during a sweep restarts it from `start_word` with the new settings. A start sampled in the cycle where the sweep would end takes priority, and no done pulse is produced.
- R9: All settings are sampled only on start. Changing them during a sweep has no effect on that sweep.
- R10: After reset, `tuning_word`, `phase`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts or restarts a sweep |
| start_word | input | 24 | First tuning word of the sweep |
| step_mag | input | 23 | Magnitude of the step |
| step_neg | input | 1 | 1 = falling sweep, 0 = rising sweep |
| incr_count | input | 12 | Number of steps N |
| dwell_count | input | 11 | Dwell length D in base units |
| dwell_by_cycles | input | 1 | 1 = count output cycles, 0 = count clock periods |
| tuning_word | output | 24 | Current frequency tuning word |
| phase | output | 24 | Phase accumulator value |
| busy | output | 1 | High while a sweep runs |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a new start and the expiry of the last dwell. The bench provokes this with a clock-mode sweep and a start timed from the known (N+1)×D length. It then checks that done stays low, busy stays high and the new start word appears. The second pair, in cycle mode, is an accumulator carry and the frequency change that the carry triggers. The bench runs random cycle-mode sweeps against a cycle-accurate reference and compares phase and tuning word on every clock. Each sweep's final word and length are also checked against closed-form values.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic {
    DWELL_CLK = 1'b0,
    DWELL_CYC = 1'b1
  } dwell_mode_e;
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] tw,
  output logic [FW-1:0] phase_q,
  output logic          wrap_q
);
  logic [FW:0] sum;
  assign sum = {1'b0, phase_q} + {1'b0, tw};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= sum[FW-1:0];
      wrap_q  <= sum[FW];
    end
  end

  // R5: a carry flag means the phase value went down
  p_wrap_drop_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_q && !$past(rst) |-> phase_q < $past(phase_q));
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] reload,
  input  logic          tick,
  output logic          expire
);
  logic [DW-1:0] left_q;

  assign expire = en && tick && (left_q == DW'(1));

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (load)
      left_q <= reload;
    else if (en && tick)
      left_q <= left_q - DW'(1);
  end

  // R6: a running dwell never sits at zero
  p_left_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    en |-> left_q != '0);
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int FW = 24,
  parameter int SW = 23,
  parameter int NW = 12,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] start_word,
  input  logic [SW-1:0] step_mag,
  input  logic          step_neg,
  input  logic [NW-1:0] incr_count,
  input  logic [DW-1:0] dwell_count,
  input  logic          dwell_by_cycles,
  input  logic          wrap,
  output logic [FW-1:0] tw_q,
  output logic          busy_q,
  output logic          done_q
);
  localparam int EXT = FW - SW;

  logic [FW-1:0] delta_q;
  logic [NW-1:0] last_q, steps_q;
  logic [DW-1:0] dwell_q, dwell_eff;
  dwell_mode_e   mode_q;
  logic          tick, expire, last, load;

  assign dwell_eff = (dwell_count < DW'(2)) ? DW'(2) : dwell_count;
  assign tick      = (mode_q == DWELL_CYC) ? wrap : 1'b1;
  assign last      = (steps_q == last_q);
  assign load      = start || (expire && !last);

  dwell_timer #(.DW(DW)) u_dwell (
    .clk(clk), .rst(rst), .en(busy_q), .load(load),
    .reload(start ? dwell_eff : dwell_q), .tick(tick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q    <= '0;
      delta_q <= '0;
      last_q  <= '0;
      steps_q <= '0;
      dwell_q <= '0;
      mode_q  <= DWELL_CLK;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        tw_q    <= start_word;
        delta_q <= step_neg ? -{{EXT{1'b0}}, step_mag} : {{EXT{1'b0}}, step_mag};
        last_q  <= (incr_count < NW'(2)) ? NW'(2) : incr_count;
        dwell_q <= dwell_eff;
        mode_q  <= dwell_by_cycles ? DWELL_CYC : DWELL_CLK;
        steps_q <= '0;
        busy_q  <= 1'b1;
      end else if (expire) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          tw_q    <= tw_q + delta_q;
          steps_q <= steps_q + NW'(1);
        end
      end
    end
  end

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q && $past(busy_q));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start |=> $stable(tw_q));
  p_start_wins_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q && !done_q);
  p_step_count_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> steps_q <= last_q);
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq #(
  parameter int FW = 24,
  parameter int SW = 23,
  parameter int NW = 12,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] start_word,
  input  logic [SW-1:0] step_mag,
  input  logic          step_neg,
  input  logic [NW-1:0] incr_count,
  input  logic [DW-1:0] dwell_count,
  input  logic          dwell_by_cycles,
  output logic [FW-1:0] tuning_word,
  output logic [FW-1:0] phase,
  output logic          busy,
  output logic          done
);
  logic wrap;

  sweep_ctrl #(.FW(FW), .SW(SW), .NW(NW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_word(start_word),
    .step_mag(step_mag), .step_neg(step_neg), .incr_count(incr_count),
    .dwell_count(dwell_count), .dwell_by_cycles(dwell_by_cycles),
    .wrap(wrap), .tw_q(tuning_word), .busy_q(busy), .done_q(done)
  );

  phase_acc #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .tw(tuning_word), .phase_q(phase), .wrap_q(wrap)
  );
endmodule

// File: tb/sim_sweep_seq.sv
module sim_sweep_seq;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] start_word = '0;
  logic [22:0] step_mag = '0;
  logic        step_neg = 1'b0;
  logic [11:0] incr_count = '0;
  logic [10:0] dwell_count = '0;
  logic        dwell_by_cycles = 1'b0;
  logic [23:0] tuning_word, phase;
  logic        busy, done;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sweep_seq u0 (.*);

  // cycle-accurate reference built from the requirements
  logic [23:0] m_tw, m_ph, m_delta;
  logic        m_wrap, m_busy, m_done, m_cyc, m_tick;
  logic [11:0] m_n, m_steps;
  logic [10:0] m_d, m_left;

  function automatic logic [23:0] signed_step(logic [22:0] mag, logic neg);
    return neg ? 24'(-{1'b0, mag}) : {1'b0, mag};
  endfunction

  function automatic logic [23:0] exp_final(logic [23:0] sw, logic [22:0] mag,
                                            logic neg, logic [11:0] n);
    logic [11:0] ne = (n < 2) ? 12'd2 : n;
    return sw + 24'(ne * signed_step(mag, neg));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tw <= '0; m_ph <= '0; m_wrap <= 0; m_busy <= 0; m_done <= 0;
      m_left <= '0; m_steps <= '0; m_n <= '0; m_d <= '0; m_cyc <= 0; m_delta <= '0;
    end else begin
      m_ph   <= m_ph + m_tw;
      m_wrap <= ({1'b0, m_ph} + {1'b0, m_tw}) > 25'hFFFFFF;
      m_done <= 0;
      m_tick = m_cyc ? m_wrap : 1'b1;
      if (start) begin
        m_tw <= start_word; m_busy <= 1; m_steps <= '0;
        m_delta <= signed_step(step_mag, step_neg);
        m_n <= (incr_count < 2) ? 12'd2 : incr_count;
        m_d <= (dwell_count < 2) ? 11'd2 : dwell_count;
        m_left <= (dwell_count < 2) ? 11'd2 : dwell_count;
        m_cyc <= dwell_by_cycles;
      end else if (m_busy && m_tick) begin
        if (m_left == 1) begin
          if (m_steps == m_n) begin m_busy <= 0; m_done <= 1; end
          else begin m_tw <= m_tw + m_delta; m_steps <= m_steps + 1; m_left <= m_d; end
        end else m_left <= m_left - 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference (R2, R5, R7, R9)
  always @(negedge clk) begin
    cyc++;
    if (!rst && !finished) begin
      check("R2 tuning_word", 32'(tuning_word), 32'(m_tw));
      check("R5 phase", 32'(phase), 32'(m_ph));
      check("R9 busy", 32'(busy), 32'(m_busy));
      check("R7 done", 32'(done), 32'(m_done));
    end
    if (cyc > 190000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(logic [23:0] sw, logic [22:0] mag, logic neg, logic [11:0] n,
                     logic [10:0] d, logic mode, bit scramble);
    int len = 0;
    logic [11:0] ne = (n < 2) ? 12'd2 : n;
    logic [10:0] de = (d < 2) ? 11'd2 : d;
    @(negedge clk);
    start_word = sw; step_mag = mag; step_neg = neg; incr_count = n;
    dwell_count = d; dwell_by_cycles = mode; start = 1;
    @(negedge clk); start = 0;
    check("R1 first word", 32'(tuning_word), 32'(sw));
    check("R1 busy", 32'(busy), 1);
    if (scramble) begin
      start_word = ~sw; step_mag = ~mag; step_neg = ~neg; incr_count = 12'd7;
      dwell_count = 11'd9; dwell_by_cycles = ~mode;
    end
    while (!done && !finished) begin @(negedge clk); len++; end
    check("R3 final word", 32'(tuning_word), 32'(exp_final(sw, mag, neg, n)));
    if (!mode) check("R4/R6 sweep length", len, (32'(ne) + 1) * 32'(de));
    @(negedge clk);
    check("R7 done width", 32'(done), 0);
    check("R7 hold", 32'(tuning_word), 32'(exp_final(sw, mag, neg, n)));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R10 tuning", 32'(tuning_word), 0);
    check("R10 phase", 32'(phase), 0);
    check("R10 busy", 32'(busy), 0);
    check("R10 done", 32'(done), 0);
    rst = 0;
    // directed corners
    run(24'h100000, 23'h001000, 0, 12'd3, 11'd5, 0, 0);   // R4 rising
    run(24'h800000, 23'h010000, 1, 12'd4, 11'd3, 0, 0);   // R2 falling
    run(24'hFFFF00, 23'h000100, 0, 12'd2, 11'd2, 0, 0);   // R2 wrap mod 2^24
    run(24'h400000, 23'h000200, 0, 12'd0, 11'd1, 0, 0);   // R6 clamps
    run(24'h300000, 23'h000040, 0, 12'd2, 11'd2047, 0, 0); // R6 max dwell
    run(24'h200000, 23'h000001, 0, 12'd4095, 11'd2, 0, 0); // R6 max steps
    run(24'h500000, 23'h000800, 1, 12'd5, 11'd4, 1, 1);   // R5 + R9
    // R8 restart mid sweep
    @(negedge clk);
    start_word = 24'h123456; step_mag = 23'h10; step_neg = 0;
    incr_count = 12'd10; dwell_count = 11'd20; dwell_by_cycles = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    start_word = 24'h654321; start = 1;
    @(negedge clk); start = 0;
    check("R8 restart word", 32'(tuning_word), 32'h654321);
    while (busy && !finished) @(negedge clk);
    // R8 start collides with end of sweep
    @(negedge clk);
    start_word = 24'h0A0000; step_mag = 23'h100; incr_count = 12'd2;
    dwell_count = 11'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    start_word = 24'h0B0000; start = 1;
    @(negedge clk); start = 0;
    check("R8 no done on collision", 32'(done), 0);
    check("R8 busy on collision", 32'(busy), 1);
    check("R8 new word on collision", 32'(tuning_word), 32'h0B0000);
    while (busy && !finished) @(negedge clk);
    // random sweeps, both dwell modes
    for (int i = 0; i < 24; i++) begin
      run(24'h400000 + 24'($urandom_range(0, 24'h3FFFFF)), 23'($urandom_range(0, 16383)),
          1'($urandom_range(0, 1)), 12'($urandom_range(0, 20)),
          11'($urandom_range(0, 8)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule